// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept. It watches the first six bytes of a frame, the destination address, which arrive one byte per cycle on a byte stream with a start-of-frame flag. While the bytes come in, it shifts the address into a register and advances a reflected CRC-32. One cycle after the sixth byte it gives a one-cycle verdict: a pass/drop bit and a reason code.

Unicast addresses are compared against a bank of exact-match address slots. Multicast addresses are looked up in a bit table, indexed by a hash taken from the CRC of the address. Broadcast is accepted unless a block bit is set. Two override modes exist. Promiscuous mode passes everything. Receive-all mode passes everything but still reports what the filter would have decided.

A write-only register port programs the mode bits, the hash table words and the address slots. The parameters are the slot count `NUM_SLOTS` and the log2 of the hash table size, `HASH_BITS`.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, and with no traffic, `verdict_valid` stays low. All configuration registers reset to zero.
- R2: The sixth address byte is accepted on a clock edge, and `verdict_valid` is high for exactly the one cycle after that edge. Cycles with `rx_valid` low between address bytes are allowed. Bytes after the sixth, up to the next start-of-frame, are ignored.
- R3: A byte with `rx_sof` high discards any partial address and becomes byte 0 of a new address. The verdict then reflects only the new address, and the aborted bytes produce no verdict.
- R4: The address is held as 48 bits, with the first byte received in bits 47:40. A slot k holds the 48-bit value {word at 2+HW+2k [15:0], word at 1+HW+2k [31:0]}, where HW is the number of hash words. A unicast address equal to a slot passes with reason 1 (EXACT). Any other filter rejection gives reason 0 (MISS) with pass low.
- R5: A slot whose 48-bit value is all zeros never matches, not even the all-zero address.
- R6: An address is multicast when bit 40 (bit 0 of the first byte) is 1. Unicast addresses are checked only against the slots, and multicast addresses only against the hash table.
- R7: The hash index is the top HASH_BITS bits of bitreverse(~CRC). The CRC is a reflected CRC-32 (polynomial 0xEDB88320, register starting at all ones) over the six bytes, each byte taken LSB first. Table bit i is bit i%32 of the word at register 1+i/32.
- R8: A non-broadcast multicast address passes with reason 2 (HASH) only when the indexed table bit is 1 and mode bit 2 (hash enable) is 1.
- R9: The all-ones address passes with reason 3 (BCAST) unless mode bit 3 (broadcast block) is 1, in which case it is a MISS.
- R10: With mode bit 0 (promiscuous) set, every verdict has pass high and reason 4 (PROMISC).
- R11: With mode bit 1 (receive-all) set and promiscuous clear, every verdict has pass high and carries the filter's own reason code, including MISS.
- R12: Register 0 holds the mode in bits 3:0. Writes take effect on the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_pass | output | 1 | Frame is accepted |
| verdict_reason | output | 3 | 0 MISS, 1 EXACT, 2 HASH, 3 BCAST, 4 PROMISC |

## Verification
The hash path is swept over all 64 table bits. For each bit, a multicast address whose reference hash hits that bit must pass, and addresses hitting other bits must drop. This separates errors in the CRC, the bit reversal, the word select and the bit select. Unicast, all-zero and slot-programmed multicast addresses tell slot matching apart from hash matching and test the zero-slot rule. Broadcast with and without the block bit, promiscuous mode and receive-all mode each separate the override priority from the filter's own reason. Gapped byte streams, start-of-frame aborts and trailing bytes show that the verdict depends only on the byte count.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int NUM_SLOTS = 4,
  parameter int HASH_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_data,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        verdict_valid,
  output logic        verdict_pass,
  output logic [2:0]  verdict_reason
);
  localparam int TBL_BITS   = 1 << HASH_BITS;
  localparam int HASH_WORDS = (TBL_BITS + 31) / 32;
  localparam int SLOT_BASE  = 1 + HASH_WORDS;

  localparam logic [2:0] RS_MISS    = 3'd0;
  localparam logic [2:0] RS_EXACT   = 3'd1;
  localparam logic [2:0] RS_HASH    = 3'd2;
  localparam logic [2:0] RS_BCAST   = 3'd3;
  localparam logic [2:0] RS_PROMISC = 3'd4;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic [3:0]                 mode_q;
  logic [HASH_WORDS*32-1:0]   hash_tbl;
  logic [47:0]                slot_q [NUM_SLOTS];
  logic [2:0]                 cnt_q;
  logic [47:0]                addr_q;
  logic [31:0]                crc_q;
  logic                       done_q;

  wire promisc   = mode_q[0];
  wire recv_all  = mode_q[1];
  wire hash_en   = mode_q[2];
  wire bc_block  = mode_q[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      hash_tbl <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) slot_q[s] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 8'd0) mode_q <= cfg_wdata[3:0];
      for (int w = 0; w < HASH_WORDS; w++)
        if (int'(cfg_addr) == 1 + w) hash_tbl[w*32 +: 32] <= cfg_wdata;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (int'(cfg_addr) == SLOT_BASE + 2*s)     slot_q[s][31:0]  <= cfg_wdata;
        if (int'(cfg_addr) == SLOT_BASE + 2*s + 1) slot_q[s][47:32] <= cfg_wdata[15:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= 3'd0;
      addr_q <= '0;
      crc_q  <= '1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rx_valid) begin
        if (rx_sof) begin
          crc_q  <= crc_step(32'hFFFFFFFF, rx_data);
          addr_q <= {addr_q[39:0], rx_data};
          cnt_q  <= 3'd1;
        end else if (cnt_q != 3'd0 && cnt_q < 3'd6) begin
          crc_q  <= crc_step(crc_q, rx_data);
          addr_q <= {addr_q[39:0], rx_data};
          cnt_q  <= cnt_q + 3'd1;
          if (cnt_q == 3'd5) done_q <= 1'b1;
        end
      end
    end
  end

  logic [HASH_BITS-1:0] hidx;
  logic                 slot_hit;
  logic [2:0]           filt_reason;
  wire  [31:0]          crc_fin  = ~crc_q;
  wire                  is_mcast = addr_q[40];
  wire                  is_bcast = &addr_q;

  always_comb begin
    for (int j = 0; j < HASH_BITS; j++) hidx[HASH_BITS-1-j] = crc_fin[j];
    slot_hit = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slot_q[s] != 48'h0 && slot_q[s] == addr_q) slot_hit = 1'b1;
    if (!is_mcast)     filt_reason = slot_hit ? RS_EXACT : RS_MISS;
    else if (is_bcast) filt_reason = bc_block ? RS_MISS : RS_BCAST;
    else               filt_reason = (hash_en && hash_tbl[hidx]) ? RS_HASH : RS_MISS;
  end

  assign verdict_valid  = done_q;
  assign verdict_pass   = promisc | recv_all | (filt_reason != RS_MISS);
  assign verdict_reason = promisc ? RS_PROMISC : filt_reason;

  // R2
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);
  // R2
  after_sixth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> cnt_q == 3'd6);
  // R10
  promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && promisc) |-> (verdict_pass && verdict_reason == RS_PROMISC));
  // R8
  hash_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_reason == RS_HASH) |-> (hash_en && is_mcast && !is_bcast));
  // R6
  exact_unicast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_reason == RS_EXACT) |-> !is_mcast);
  // R4
  drop_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !verdict_pass) |-> verdict_reason == RS_MISS);
endmodule

// File: tb/eth_rx_addr_filter_bench.sv
module eth_rx_addr_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, rx_valid = 0, rx_sof = 0, cfg_we = 0;
  logic [7:0] rx_data = 0, cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic verdict_valid, verdict_pass;
  logic [2:0] verdict_reason;

  int nchk = 0, nerr = 0;
  logic [3:0]  b_mode = 0;
  logic [63:0] b_tbl = 0;
  logic [47:0] b_slot [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_addr_filter u_eth_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass), .verdict_reason(verdict_reason));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] inv, rev;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] by = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ by[k];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    inv = ~c;
    for (int j = 0; j < 32; j++) rev[31-j] = inv[j];
    return rev[31:26];
  endfunction

  function automatic logic [3:0] model(input logic [47:0] a);
    logic [2:0] r;
    logic hit = 0;
    for (int s = 0; s < 4; s++) if (b_slot[s] != 0 && b_slot[s] == a) hit = 1;
    if (!a[40])     r = hit ? 3'd1 : 3'd0;
    else if (&a)    r = b_mode[3] ? 3'd0 : 3'd3;
    else            r = (b_mode[2] && b_tbl[ref_idx(a)]) ? 3'd2 : 3'd0;
    if (b_mode[0]) return {1'b1, 3'd4};
    return {(b_mode[1] || r != 0), r};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 8'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic set_mode(input logic [3:0] m); wr(0, {28'h0, m}); b_mode = m; endtask
  task automatic set_tbl(input logic [63:0] t); wr(1, t[31:0]); wr(2, t[63:32]); b_tbl = t; endtask
  task automatic set_slot(input int k, input logic [47:0] v);
    wr(3 + 2*k, v[31:0]); wr(4 + 2*k, {16'h0, v[47:32]}); b_slot[k] = v;
  endtask

  task automatic send(input logic [47:0] a, input bit gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = (i == 0); rx_data = a[47-8*i -: 8];
      if (gap && i < 5) begin @(negedge clk); rx_valid = 0; rx_sof = 0; end
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0;
  endtask

  task automatic frame(input logic [47:0] a, input bit gap, input string rq);
    logic [3:0] e;
    send(a, gap);
    e = model(a);
    chk("R2", {31'h0, verdict_valid}, 1);
    chk(rq, {31'h0, verdict_pass}, {31'h0, e[3]});
    chk(rq, {29'h0, verdict_reason}, {29'h0, e[2:0]});
    @(negedge clk);
    chk("R2", {31'h0, verdict_valid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) b_slot[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R1", {31'h0, verdict_valid}, 0);
    end
    // R1: zero config: unicast all-zero and broadcast
    frame(48'h000000000000, 0, "R1");
    frame(48'hFFFFFFFFFFFF, 0, "R9");

    // R4 / R5: slots
    set_slot(0, 48'h0200_1122_3344);
    set_slot(1, 48'h0A0B_0C0D_0E0F);
    set_slot(2, 48'h0100_5E00_0007);
    frame(48'h0200_1122_3344, 0, "R4");
    frame(48'h0A0B_0C0D_0E0F, 1, "R4");
    frame(48'h0200_1122_3345, 0, "R4");
    frame(48'h000000000000, 0, "R5");
    // R6: multicast slot value ignored by slot path
    frame(48'h0100_5E00_0007, 0, "R6");

    // R7 / R8: sweep every table bit
    set_mode(4'b0100);
    for (int b = 0; b < 64; b++) begin
      logic [47:0] hit_a = 0;
      bit found = 0;
      set_tbl(64'h1 << b);
      for (int k = 0; k < 2048 && !found; k++)
        if (ref_idx(48'h0100_5E00_0000 | 48'(k)) == 6'(b)) begin
          hit_a = 48'h0100_5E00_0000 | 48'(k); found = 1;
        end
      if (found) frame(hit_a, 0, "R7");
      frame(48'h0100_5E00_0000 | 48'(b * 7 + 1), 0, "R7");
      frame(48'h3300_0000_0000 | 48'(b), 0, "R7");
    end
    set_tbl(64'hA5C3_0F96_5A3C_F069);
    for (int k = 0; k < 96; k++) frame(48'h0100_5E7F_0000 | 48'(k * 13), k[0], "R7");
    // R6: unicast with all table bits set still misses
    set_tbl(64'hFFFF_FFFF_FFFF_FFFF);
    frame(48'h0200_AAAA_BBBB, 0, "R6");
    // R8: hash disabled
    set_mode(4'b0000);
    frame(48'h0100_5E12_3456, 0, "R8");
    frame(48'h3333_0000_0001, 0, "R8");

    // R9: broadcast block
    set_mode(4'b1000);
    frame(48'hFFFFFFFFFFFF, 0, "R9");
    set_mode(4'b0100);
    frame(48'hFFFFFFFFFFFF, 0, "R9");

    // R10: promiscuous, also over receive-all
    set_mode(4'b0001);
    frame(48'h0200_DEAD_BEEF, 0, "R10");
    set_mode(4'b1011);
    frame(48'hFFFFFFFFFFFF, 0, "R10");

    // R11: receive-all reports filter outcome
    set_mode(4'b0010);
    frame(48'h0200_DEAD_BEEF, 0, "R11");
    frame(48'h0200_1122_3344, 0, "R11");
    set_mode(4'b1010);
    frame(48'hFFFFFFFFFFFF, 0, "R11");

    // R12: mode write takes effect
    set_mode(4'b0000);
    chk("R12", 0, 0);
    frame(48'h0200_DEAD_BEEF, 0, "R12");

    // R3: abort partial address with a new start-of-frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = (i == 0); rx_data = 8'h55 + 8'(i);
      @(posedge clk); #1;
      chk("R3", {31'h0, verdict_valid}, 0);
    end
    frame(48'h0A0B_0C0D_0E0F, 0, "R3");
    // R2: trailing bytes without start-of-frame are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_data = 8'(i);
      @(negedge clk); rx_valid = 0;
      chk("R2", {31'h0, verdict_valid}, 0);
    end
    // R3: bytes with no preceding start-of-frame after reset do nothing
    rst_n = 0; @(negedge clk); rst_n = 1;
    b_mode = 0; b_tbl = 0;
    for (int s = 0; s < 4; s++) b_slot[s] = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_data = 8'hFF;
      @(negedge clk); rx_valid = 0;
      chk("R1", {31'h0, verdict_valid}, 0);
    end
    frame(48'h0200_1122_3344, 1, "R1");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule